// File: doc/BRIEF.md
# Program Bank Slot Register File

This block maps the upper part of a 16-bit CPU address space onto a program memory of up to 1 MiB, one 8 KiB slot at a time. Five slot registers cover the CPU windows $6000-$7FFF, $8000-$9FFF, $A000-$BFFF, $C000-$DFFF and $E000-$FFFF. Each register holds a 7-bit bank number, which becomes program address bits 19..13, and one select bit that routes the access either to the ROM chip select or to the RAM chip select. The register file is loaded through a simple port-write interface: a 4-bit port number and an 8-bit value, qualified by a write enable.

The block also watches the CPU's M2 clock on its own free-running clock. When M2 stops toggling for a set number of clocks, the register for the top window is forced to ROM bank $7F. The last ROM bank, which holds the reset vectors, then sits at $E000-$FFFF, so a CPU that restarts always fetches its vectors from a known place. The CPU supplies only address bits 15..13. The bank number and the chip selects come out of registers, one clock after the address.

Top module: `prg_bank_file`

## Requirements
- R1: While `rst` is high, the four lower slot registers clear to $00, the top slot register loads $7F, and the outputs clear to zero with both chip selects low.
- R2: A write with `wr_en` high loads `wr_data` into a slot register. Port 6 selects $6000, port 8 selects $8000, port 10 selects $A000, port 12 selects $C000 and port 14 selects $E000. The new value shows on the outputs from the second clock after the write.
- R3: A write to any other port number (0-5, 7, 9, 11, 13 or 15) changes no slot register.
- R4: The outputs are registered. For the page on `cpu_a_hi` at a clock edge, `prg_bank` takes bits 6..0 of that page's slot register as it stood before that edge. A write in the same cycle is not yet visible.
- R5: Bit 7 of the slot value picks the chip. With bit 7 = 0, `rom_cs` is 1 and `ram_cs` is 0. With bit 7 = 1, `ram_cs` is 1 and `rom_cs` is 0.
- R6: For pages 0-2 (addresses below $6000), both chip selects are 0 and `prg_bank` is 0.
- R7: M2 is passed through a two-stage synchronizer. If no M2 edge (rising or falling) is seen for `M2_TIMEOUT` clocks in a row, M2 is lost. While M2 is lost, the top slot register is reloaded with $7F on every clock.
- R8: While M2 is lost, the $7F fallback wins over a write to port 14 in the same cycle. Writes to the other slot ports still take effect.
- R9: Once M2 edges are seen again, the forcing stops. The top slot keeps $7F until software writes port 14.
- R10: `rom_cs` and `ram_cs` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst | input | 1 | Synchronous active-high reset |
| m2 | input | 1 | CPU M2 clock, asynchronous to `clk` |
| cpu_a_hi | input | 3 | CPU address bits 15..13 (page number) |
| wr_en | input | 1 | Port write strobe, one clock per write |
| wr_port | input | 4 | Port number of the write |
| wr_data | input | 8 | Write value: bit 7 selects RAM, bits 6..0 give the bank |
| prg_bank | output | 7 | Program address bits 19..13 |
| rom_cs | output | 1 | ROM chip select, active high |
| ram_cs | output | 1 | RAM chip select, active high |

## Verification
Two events can fall in the same cycle: the fallback that rewrites the top slot after M2 has been lost, and a software write to port 14. The bench stops its M2 toggler for longer than the timeout. While M2 is lost, it writes port 14 and port 6 and then reads both windows back through the outputs. $E000 must still map ROM bank $7F, and $6000 must show the new value. After M2 restarts, the bench checks that $7F persists until port 14 is written again.

// File: rtl/prgbk_pkg.sv
package prgbk_pkg;

  localparam int unsigned BANK_W = 7;
  localparam int unsigned PORT_W = 4;
  localparam int unsigned PAGE_W = 3;

  // One slot: chip choice in the top bit, bank number below it
  typedef struct packed {
    logic                use_ram;
    logic [BANK_W-1:0]   bank;
  } slot_t;

  localparam slot_t SLOT_CLEAR    = '{use_ram: 1'b0, bank: '0};
  localparam slot_t SLOT_LAST_ROM = '{use_ram: 1'b0, bank: {BANK_W{1'b1}}};

endpackage

// File: rtl/prgbk_m2_watch.sv
module prgbk_m2_watch #(
  parameter int unsigned TIMEOUT     = 64,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic m2,
  output logic lost
);

  localparam int unsigned CNT_W = $clog2(TIMEOUT + 1);
  localparam logic [CNT_W-1:0] CNT_LIMIT = CNT_W'(TIMEOUT);

  // Synchronizer chain plus one extra stage for edge detection
  logic [SYNC_STAGES:0] sync_q;
  logic                 m2_edge;
  logic [CNT_W-1:0]     quiet_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-1:0], m2};
    end
  end

  assign m2_edge = sync_q[SYNC_STAGES] ^ sync_q[SYNC_STAGES-1];

  // Clocks since the last observed M2 edge, saturating at the limit
  always_ff @(posedge clk) begin
    if (rst) begin
      quiet_cnt <= '0;
    end else if (m2_edge) begin
      quiet_cnt <= '0;
    end else if (quiet_cnt != CNT_LIMIT) begin
      quiet_cnt <= quiet_cnt + 1'b1;
    end
  end

  assign lost = (quiet_cnt == CNT_LIMIT);

endmodule

// File: rtl/prgbk_slot_file.sv
module prgbk_slot_file
  import prgbk_pkg::*;
#(
  parameter int unsigned SLOTS     = 5,
  parameter int unsigned BASE_PORT = 6,
  parameter int unsigned PORT_STEP = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [PORT_W-1:0]     wr_port,
  input  slot_t                 wr_value,
  input  logic                  force_top,
  output slot_t [SLOTS-1:0]     slots_q
);

  localparam int unsigned TOP = SLOTS - 1;

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    localparam logic [PORT_W-1:0] MY_PORT = PORT_W'(BASE_PORT + PORT_STEP * i);
    logic hit;
    assign hit = wr_en && (wr_port == MY_PORT);

    if (i == TOP) begin : g_top
      // Fallback outranks software writes
      always_ff @(posedge clk) begin
        if (rst) begin
          slots_q[i] <= SLOT_LAST_ROM;
        end else if (force_top) begin
          slots_q[i] <= SLOT_LAST_ROM;
        end else if (hit) begin
          slots_q[i] <= wr_value;
        end
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (rst) begin
          slots_q[i] <= SLOT_CLEAR;
        end else if (hit) begin
          slots_q[i] <= wr_value;
        end
      end
    end
  end

endmodule

// File: rtl/prgbk_addr_map.sv
module prgbk_addr_map
  import prgbk_pkg::*;
#(
  parameter int unsigned SLOTS      = 5,
  parameter int unsigned FIRST_PAGE = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [PAGE_W-1:0]     page,
  input  slot_t [SLOTS-1:0]     slots,
  output logic [BANK_W-1:0]     prg_bank,
  output logic                  rom_cs,
  output logic                  ram_cs
);

  slot_t pick;
  logic  in_window;

  always_comb begin
    pick      = SLOT_CLEAR;
    in_window = 1'b0;
    for (int i = 0; i < SLOTS; i++) begin
      if (page == PAGE_W'(FIRST_PAGE + i)) begin
        pick      = slots[i];
        in_window = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prg_bank <= '0;
      rom_cs   <= 1'b0;
      ram_cs   <= 1'b0;
    end else begin
      prg_bank <= in_window ? pick.bank : '0;
      rom_cs   <= in_window && !pick.use_ram;
      ram_cs   <= in_window &&  pick.use_ram;
    end
  end

endmodule

// File: rtl/prg_bank_file.sv
module prg_bank_file
  import prgbk_pkg::*;
#(
  parameter int unsigned SLOT_COUNT  = 5,
  parameter int unsigned M2_TIMEOUT  = 64,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 m2,
  input  logic [PAGE_W-1:0]    cpu_a_hi,
  input  logic                 wr_en,
  input  logic [PORT_W-1:0]    wr_port,
  input  logic [BANK_W:0]      wr_data,
  output logic [BANK_W-1:0]    prg_bank,
  output logic                 rom_cs,
  output logic                 ram_cs
);

  localparam int unsigned FIRST_PAGE = (1 << PAGE_W) - SLOT_COUNT;

  slot_t [SLOT_COUNT-1:0] slots_q;
  logic                   m2_lost;

  prgbk_m2_watch #(
    .TIMEOUT     (M2_TIMEOUT),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_watch (
    .clk  (clk),
    .rst  (rst),
    .m2   (m2),
    .lost (m2_lost)
  );

  prgbk_slot_file #(
    .SLOTS     (SLOT_COUNT),
    .BASE_PORT (6),
    .PORT_STEP (2)
  ) u_slots (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_port   (wr_port),
    .wr_value  (slot_t'(wr_data)),
    .force_top (m2_lost),
    .slots_q   (slots_q)
  );

  prgbk_addr_map #(
    .SLOTS      (SLOT_COUNT),
    .FIRST_PAGE (FIRST_PAGE)
  ) u_map (
    .clk      (clk),
    .rst      (rst),
    .page     (cpu_a_hi),
    .slots    (slots_q),
    .prg_bank (prg_bank),
    .rom_cs   (rom_cs),
    .ram_cs   (ram_cs)
  );

endmodule

// File: rtl/prg_bank_file_chk.sv
module prg_bank_file_chk (
  input logic       clk,
  input logic       rst,
  input logic [2:0] cpu_a_hi,
  input logic       wr_en,
  input logic [3:0] wr_port,
  input logic [7:0] wr_data,
  input logic [6:0] prg_bank,
  input logic       rom_cs,
  input logic       ram_cs,
  input logic       m2_lost,
  input logic [7:0] top_slot,
  input logic [7:0] first_slot
);

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (top_slot == 8'h7F && first_slot == 8'h00 && !rom_cs && !ram_cs)); // R1

  AST_PORT6_LOAD: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_port == 4'd6) |=> (first_slot == $past(wr_data))); // R2

  AST_TOP_CHIP_PICK: assert property (@(posedge clk) disable iff (rst)
    (cpu_a_hi == 3'd7) |=> (ram_cs == $past(top_slot[7]) && rom_cs == !$past(top_slot[7]))); // R5

  AST_LOW_PAGE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (cpu_a_hi < 3'd3) |=> (!rom_cs && !ram_cs && prg_bank == 7'd0)); // R6

  AST_LOST_FORCES_TOP: assert property (@(posedge clk) disable iff (rst)
    m2_lost |=> (top_slot == 8'h7F)); // R7

  AST_LOST_BEATS_WRITE: assert property (@(posedge clk) disable iff (rst)
    (m2_lost && wr_en && wr_port == 4'd14) |=> (top_slot == 8'h7F)); // R8

  AST_CS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rom_cs, ram_cs})); // R10

endmodule

bind prg_bank_file prg_bank_file_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .cpu_a_hi   (cpu_a_hi),
  .wr_en      (wr_en),
  .wr_port    (wr_port),
  .wr_data    (wr_data),
  .prg_bank   (prg_bank),
  .rom_cs     (rom_cs),
  .ram_cs     (ram_cs),
  .m2_lost    (m2_lost),
  .top_slot   (slots_q[SLOT_COUNT-1]),
  .first_slot (slots_q[0])
);

// File: tb/tb_prg_bank_file.sv
module tb_prg_bank_file;

  localparam int CLK_PERIOD = 10;
  localparam int TIMEOUT    = 64;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       m2  = 1'b0;
  logic [2:0] cpu_a_hi = 3'd0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_port = 4'd0;
  logic [7:0] wr_data = 8'd0;
  logic [6:0] prg_bank;
  logic       rom_cs, ram_cs;

  int    total = 0;
  int    bad   = 0;
  string cur_req = "R1";
  bit    m2_run = 1'b1;
  bit    done = 1'b0;

  // Reference model state
  logic [7:0] slot_m [5];
  bit         hist [$];
  int         quiet_m;
  logic [6:0] exp_bank;
  logic       exp_rom, exp_ram;

  prg_bank_file #(.M2_TIMEOUT(TIMEOUT)) dut (
    .clk(clk), .rst(rst), .m2(m2), .cpu_a_hi(cpu_a_hi),
    .wr_en(wr_en), .wr_port(wr_port), .wr_data(wr_data),
    .prg_bank(prg_bank), .rom_cs(rom_cs), .ram_cs(ram_cs)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // M2 toggler: an edge every third clock while running
  initial begin
    forever begin
      repeat (3) @(negedge clk);
      if (m2_run) m2 = ~m2;
    end
  end

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 4; i++) slot_m[i] = 8'h00;
      slot_m[4] = 8'h7F;
      hist = '{0, 0, 0};
      quiet_m = 0;
      exp_bank = 0; exp_rom = 0; exp_ram = 0;
    end else begin
      bit lost_now, edge_now;
      int pg;
      pg = int'(cpu_a_hi);
      if (pg >= 3) begin
        exp_bank = slot_m[pg-3][6:0];
        exp_ram  = slot_m[pg-3][7];
        exp_rom  = !slot_m[pg-3][7];
      end else begin
        exp_bank = 0; exp_rom = 0; exp_ram = 0;
      end
      lost_now = (quiet_m == TIMEOUT);
      edge_now = (hist[1] != hist[2]);
      hist.push_front(m2);
      void'(hist.pop_back());
      if (edge_now) quiet_m = 0;
      else if (quiet_m < TIMEOUT) quiet_m++;
      if (wr_en && wr_port >= 6 && wr_port[0] == 1'b0) begin
        int idx;
        idx = (int'(wr_port) - 6) / 2;
        if (!(idx == 4 && lost_now)) slot_m[idx] = wr_data;
      end
      if (lost_now) slot_m[4] = 8'h7F;
    end
  end

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      total++;
      if (prg_bank !== exp_bank || rom_cs !== exp_rom || ram_cs !== exp_ram) begin
        bad++;
        $display("FAIL %s model: got bank=%h rom=%b ram=%b expected bank=%h rom=%b ram=%b",
                 cur_req, prg_bank, rom_cs, ram_cs, exp_bank, exp_rom, exp_ram);
      end
    end
  end

  task automatic wr(input logic [3:0] p, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_port = p; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic probe(input string tag, input logic [2:0] pg,
                       input logic [6:0] eb, input logic er, input logic em);
    @(negedge clk); cpu_a_hi = pg; wr_en = 1'b0;
    @(negedge clk);
    total++;
    if (prg_bank !== eb || rom_cs !== er || ram_cs !== em) begin
      bad++;
      $display("FAIL %s page %0d: got bank=%h rom=%b ram=%b expected bank=%h rom=%b ram=%b",
               tag, pg, prg_bank, rom_cs, ram_cs, eb, er, em);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset values
    cur_req = "R1";
    probe("R1", 3'd7, 7'h7F, 1'b1, 1'b0);
    probe("R1", 3'd3, 7'h00, 1'b1, 1'b0);
    // R6 low pages
    cur_req = "R6";
    probe("R6", 3'd1, 7'h00, 1'b0, 1'b0);
    // R2 / R5 loads
    cur_req = "R2";
    wr(4'd6, 8'h11); wr(4'd8, 8'h85); wr(4'd10, 8'h22); wr(4'd12, 8'hC3); wr(4'd14, 8'h40);
    probe("R2", 3'd3, 7'h11, 1'b1, 1'b0);
    probe("R5", 3'd4, 7'h05, 1'b0, 1'b1);
    probe("R2", 3'd5, 7'h22, 1'b1, 1'b0);
    probe("R5", 3'd6, 7'h43, 1'b0, 1'b1);
    probe("R2", 3'd7, 7'h40, 1'b1, 1'b0);
    // R3 other ports ignored
    cur_req = "R3";
    wr(4'd7, 8'hFF); wr(4'd13, 8'hFF); wr(4'd15, 8'hFF); wr(4'd0, 8'hFF); wr(4'd5, 8'hFF);
    probe("R3", 3'd3, 7'h11, 1'b1, 1'b0);
    probe("R3", 3'd6, 7'h43, 1'b0, 1'b1);
    probe("R3", 3'd7, 7'h40, 1'b1, 1'b0);
    // R4 write not visible in the same cycle
    cur_req = "R4";
    @(negedge clk); cpu_a_hi = 3'd5; wr_en = 1'b1; wr_port = 4'd10; wr_data = 8'h33;
    @(negedge clk); wr_en = 1'b0;
    total++;
    if (prg_bank !== 7'h22) begin
      bad++; $display("FAIL R4 same-cycle: got bank=%h expected bank=22", prg_bank);
    end
    @(negedge clk);
    total++;
    if (prg_bank !== 7'h33) begin
      bad++; $display("FAIL R4 next-cycle: got bank=%h expected bank=33", prg_bank);
    end
    // R4 random sweep, judged by the model
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      cpu_a_hi = 3'($urandom_range(0, 7));
      wr_en    = ($urandom_range(0, 2) == 0);
      wr_port  = 4'($urandom_range(0, 15));
      wr_data  = 8'($urandom_range(0, 255));
    end
    @(negedge clk); wr_en = 1'b0;
    // R7 M2 loss
    cur_req = "R7";
    wr(4'd14, 8'h2A);
    probe("R7", 3'd7, 7'h2A, 1'b1, 1'b0);
    m2_run = 1'b0;
    repeat (TIMEOUT + 12) @(negedge clk);
    probe("R7", 3'd7, 7'h7F, 1'b1, 1'b0);
    // R8 fallback beats port 14, port 6 still loads
    cur_req = "R8";
    wr(4'd14, 8'h12);
    wr(4'd6, 8'h55);
    probe("R8", 3'd7, 7'h7F, 1'b1, 1'b0);
    probe("R8", 3'd3, 7'h55, 1'b1, 1'b0);
    // R9 recovery
    cur_req = "R9";
    m2_run = 1'b1;
    repeat (12) @(negedge clk);
    probe("R9", 3'd7, 7'h7F, 1'b1, 1'b0);
    wr(4'd14, 8'h89);
    probe("R9", 3'd7, 7'h09, 1'b0, 1'b1);
    // R10 exclusivity over a page sweep
    cur_req = "R10";
    for (int p = 0; p < 8; p++) begin
      @(negedge clk); cpu_a_hi = 3'(p);
      @(negedge clk);
      total++;
      if (rom_cs && ram_cs) begin
        bad++; $display("FAIL R10 page %0d: got rom=1 ram=1 expected at most one", p);
      end
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule